// File: doc/BRIEF.md
# Vector Segment Load Sequencer

This block runs one vector load request from start to finish. A pulse on `startIn` captures a request. The request holds a base address, an element size, a stride value, an addressing choice, a table of per-element index values, a segment length, a vector length and predicate controls. The block then walks the elements and emits one memory read for every register that the load fills. Each returned word goes to the register-file write port together with its destination register and element number.

The load has three addressing forms. The unit form steps by the element size. The constant form steps by the supplied stride. The gather form takes a per-element offset from the index table, and the index flag alone selects it. On top of any form, each element can fill several consecutive registers (a segment), each at the next stride step. Predicated-off elements are skipped, and their registers are left untouched.

Top module: `seg_load_unit`

## Requirements
- R1: With `unitStrideIn` = 1 the step between segment words, and between consecutive elements, is `elemSizeIn`, and `strideIn` has no effect on any address.
- R2: With `unitStrideIn` = 0 the step is the value of `strideIn`.
- R3: With `indexedIn` = 1 the offset of element i is the XLEN-bit slice i of `idxVecIn`, taken from bits i*XLEN upward.
- R4: With `indexedIn` = 0 the offset of element i is i × (segLen + 1) × step.
- R5: Segment word j (0 ≤ j ≤ segLen) of element i is read from base + offset + j × step and written to register (rd + j) mod 2^REG_W, with `rfWrElem` = i.
- R6: With `predEnIn` = 1, element i is loaded only when bit i of `predMaskIn` XOR `predInvIn` is 1. Otherwise none of its registers are written and no read is issued for it. With `predEnIn` = 0 every element below VL is loaded.
- R7: Memory reads have one cycle of latency. Each read issued in cycle n produces exactly one register write in cycle n+1 carrying `memRdData` of that cycle, and no write occurs otherwise.
- R8: All address sums and products wrap modulo 2^XLEN.
- R9: Reads and writes occur in increasing element order, and in increasing segment order within an element.
- R10: After reset the block is idle: `busyOut`, `doneOut`, `memRdEn` and `rfWrEn` are 0.
- R11: `busyOut` stays high for one cycle per issued read, plus one cycle per skipped element, plus two. `doneOut` pulses for exactly one cycle in the last busy cycle. With VL = 0 no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start pulse, sampled while idle |
| baseIn | input | XLEN | Base address |
| elemSizeIn | input | XLEN | Element size in address units |
| strideIn | input | XLEN | Constant stride value |
| unitStrideIn | input | 1 | 1 = step by element size |
| indexedIn | input | 1 | 1 = per-element offsets from index table |
| idxVecIn | input | MAX_VL*XLEN | Index table, element i at bits i*XLEN upward |
| segLenIn | input | SEG_W | Registers per element minus one |
| vlIn | input | VL_W | Vector length, 0..MAX_VL |
| predEnIn | input | 1 | Predication enable |
| predInvIn | input | 1 | Invert predicate bits |
| predMaskIn | input | MAX_VL | Predicate bit per element |
| rdIn | input | REG_W | First destination register |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | XLEN | Memory read address |
| memRdData | input | XLEN | Read data, one cycle after the strobe |
| rfWrEn | output | 1 | Register write strobe |
| rfWrReg | output | REG_W | Destination register |
| rfWrElem | output | IDX_W | Destination element number |
| rfWrData | output | XLEN | Write data |
| busyOut | output | 1 | Request in progress |
| doneOut | output | 1 | Last cycle of the request |

## Verification
The assertions assume that `startIn` is raised only while `busyOut` is low and that `vlIn` never exceeds MAX_VL. They also assume the memory always answers a read on the following cycle. The stimulus waits for `doneOut`, and then for one idle cycle, before it starts another request. It keeps every vector length within 0..8, and its memory model registers read data on every clock edge. Under these conditions the segment counter steps by one between back-to-back reads of the same element, and every write is paired with the read one cycle earlier.

// File: rtl/sldu_pkg.sv
package sldu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture request operands this cycle
    logic issue;  // issue a memory read for (elem, seg) this cycle
  } seq_strobe_t;

endpackage

// File: rtl/sldu_ctrl.sv
module sldu_ctrl
  import sldu_pkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int SEG_W  = 3,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [VL_W-1:0]   vlIn,
  input  logic [SEG_W-1:0]  segLenIn,
  input  logic              predEnIn,
  input  logic              predInvIn,
  input  logic [MAX_VL-1:0] predMaskIn,
  output seq_strobe_t       ctrlOut,
  output logic [IDX_W-1:0]  elemOut,
  output logic [SEG_W-1:0]  segOut,
  output logic              busyOut,
  output logic              doneOut
);

  seq_state_t        stateQ;
  logic [VL_W-1:0]   elemQ;
  logic [VL_W-1:0]   vlQ;
  logic [SEG_W-1:0]  segQ;
  logic [SEG_W-1:0]  segLenQ;
  logic              predEnQ;
  logic              predInvQ;
  logic [MAX_VL-1:0] maskQ;

  logic atEnd;
  logic elemOn;
  logic lastSeg;

  assign atEnd   = (elemQ == vlQ);
  assign elemOn  = !predEnQ || (maskQ[elemQ[IDX_W-1:0]] ^ predInvQ);
  assign lastSeg = (segQ == segLenQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      elemQ    <= '0;
      vlQ      <= '0;
      segQ     <= '0;
      segLenQ  <= '0;
      predEnQ  <= 1'b0;
      predInvQ <= 1'b0;
      maskQ    <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (startIn) begin
            vlQ      <= vlIn;
            segLenQ  <= segLenIn;
            predEnQ  <= predEnIn;
            predInvQ <= predInvIn;
            maskQ    <= predMaskIn;
            elemQ    <= '0;
            segQ     <= '0;
            stateQ   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (atEnd) begin
            stateQ <= ST_FIN;
          end else if (!elemOn || lastSeg) begin
            elemQ <= elemQ + VL_W'(1);
            segQ  <= '0;
          end else begin
            segQ <= segQ + SEG_W'(1);
          end
        end
        ST_FIN:  stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign ctrlOut.load  = (stateQ == ST_IDLE) && startIn;
  assign ctrlOut.issue = (stateQ == ST_RUN) && !atEnd && elemOn;
  assign elemOut       = elemQ[IDX_W-1:0];
  assign segOut        = segQ;
  assign busyOut       = (stateQ != ST_IDLE);
  assign doneOut       = (stateQ == ST_FIN);

  // R9: back-to-back reads of one element advance the segment by one
  a_r9_seg_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut.issue && $past(ctrlOut.issue) && elemOut == $past(elemOut))
      |-> (segOut == SEG_W'($past(segOut) + 1'b1)));

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R10: no read while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |-> !ctrlOut.issue);

  // R11: completion is followed by idle
  a_r11_done_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !busyOut);

endmodule

// File: rtl/sldu_dpath.sv
module sldu_dpath
  import sldu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int MAX_VL = 8,
  parameter int SEG_W  = 3,
  parameter int REG_W  = 5,
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seq_strobe_t            ctrlIn,
  input  logic [IDX_W-1:0]       elemIn,
  input  logic [SEG_W-1:0]       segIn,
  input  logic [XLEN-1:0]        baseIn,
  input  logic [XLEN-1:0]        elemSizeIn,
  input  logic [XLEN-1:0]        strideIn,
  input  logic                   unitStrideIn,
  input  logic                   indexedIn,
  input  logic [MAX_VL*XLEN-1:0] idxVecIn,
  input  logic [SEG_W-1:0]       segLenIn,
  input  logic [REG_W-1:0]       rdIn,
  output logic                   memRdEn,
  output logic [XLEN-1:0]        memAddr,
  input  logic [XLEN-1:0]        memRdData,
  output logic                   rfWrEn,
  output logic [REG_W-1:0]       rfWrReg,
  output logic [IDX_W-1:0]       rfWrElem,
  output logic [XLEN-1:0]        rfWrData
);

  logic [XLEN-1:0]  baseQ;
  logic [XLEN-1:0]  stepQ;
  logic             indexedQ;
  logic [SEG_W-1:0] segLenQ;
  logic [REG_W-1:0] rdQ;
  logic [XLEN-1:0]  idxQ [MAX_VL];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ    <= '0;
      stepQ    <= '0;
      indexedQ <= 1'b0;
      segLenQ  <= '0;
      rdQ      <= '0;
    end else if (ctrlIn.load) begin
      baseQ    <= baseIn;
      stepQ    <= unitStrideIn ? elemSizeIn : strideIn;
      indexedQ <= indexedIn;
      segLenQ  <= segLenIn;
      rdQ      <= rdIn;
    end
  end

  for (genvar k = 0; k < MAX_VL; k++) begin : g_idx
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            idxQ[k] <= '0;
      else if (ctrlIn.load) idxQ[k] <= idxVecIn[k*XLEN +: XLEN];
    end
  end

  // address generation, all modulo 2^XLEN
  logic [XLEN-1:0] segSpan;
  logic [XLEN-1:0] strideOff;
  logic [XLEN-1:0] elemOff;
  logic [XLEN-1:0] segOff;

  always_comb begin
    segSpan   = XLEN'(segLenQ) + XLEN'(1);
    strideOff = XLEN'(elemIn) * segSpan * stepQ;
    elemOff   = indexedQ ? idxQ[elemIn] : strideOff;
    segOff    = XLEN'(segIn) * stepQ;
  end

  assign memRdEn = ctrlIn.issue;
  assign memAddr = baseQ + elemOff + segOff;

  // write tag travels alongside the read
  logic             wrEnQ;
  logic [REG_W-1:0] wrRegQ;
  logic [IDX_W-1:0] wrElemQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEnQ   <= 1'b0;
      wrRegQ  <= '0;
      wrElemQ <= '0;
    end else begin
      wrEnQ <= ctrlIn.issue;
      if (ctrlIn.issue) begin
        wrRegQ  <= rdQ + REG_W'(segIn);
        wrElemQ <= elemIn;
      end
    end
  end

  assign rfWrEn   = wrEnQ;
  assign rfWrReg  = wrRegQ;
  assign rfWrElem = wrElemQ;
  assign rfWrData = memRdData;

  // R7: every read is answered by a write on the next cycle
  a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.issue |=> rfWrEn);

  // R7: every write has a read one cycle before it
  a_r7_write_has_read: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> $past(ctrlIn.issue));

  // R9: writes within one element target consecutive registers
  a_r9_reg_step: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && $past(rfWrEn) && rfWrElem == $past(rfWrElem))
      |-> (rfWrReg == REG_W'($past(rfWrReg) + 1'b1)));

endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import sldu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int MAX_VL = 8,
  parameter int SEG_W  = 3,
  parameter int REG_W  = 5,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startIn,
  input  logic [XLEN-1:0]        baseIn,
  input  logic [XLEN-1:0]        elemSizeIn,
  input  logic [XLEN-1:0]        strideIn,
  input  logic                   unitStrideIn,
  input  logic                   indexedIn,
  input  logic [MAX_VL*XLEN-1:0] idxVecIn,
  input  logic [SEG_W-1:0]       segLenIn,
  input  logic [VL_W-1:0]        vlIn,
  input  logic                   predEnIn,
  input  logic                   predInvIn,
  input  logic [MAX_VL-1:0]      predMaskIn,
  input  logic [REG_W-1:0]       rdIn,
  output logic                   memRdEn,
  output logic [XLEN-1:0]        memAddr,
  input  logic [XLEN-1:0]        memRdData,
  output logic                   rfWrEn,
  output logic [REG_W-1:0]       rfWrReg,
  output logic [IDX_W-1:0]       rfWrElem,
  output logic [XLEN-1:0]        rfWrData,
  output logic                   busyOut,
  output logic                   doneOut
);

  seq_strobe_t      strobe;
  logic [IDX_W-1:0] elemIdx;
  logic [SEG_W-1:0] segIdx;

  sldu_ctrl #(
    .MAX_VL(MAX_VL),
    .SEG_W (SEG_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .vlIn      (vlIn),
    .segLenIn  (segLenIn),
    .predEnIn  (predEnIn),
    .predInvIn (predInvIn),
    .predMaskIn(predMaskIn),
    .ctrlOut   (strobe),
    .elemOut   (elemIdx),
    .segOut    (segIdx),
    .busyOut   (busyOut),
    .doneOut   (doneOut)
  );

  sldu_dpath #(
    .XLEN  (XLEN),
    .MAX_VL(MAX_VL),
    .SEG_W (SEG_W),
    .REG_W (REG_W)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlIn      (strobe),
    .elemIn      (elemIdx),
    .segIn       (segIdx),
    .baseIn      (baseIn),
    .elemSizeIn  (elemSizeIn),
    .strideIn    (strideIn),
    .unitStrideIn(unitStrideIn),
    .indexedIn   (indexedIn),
    .idxVecIn    (idxVecIn),
    .segLenIn    (segLenIn),
    .rdIn        (rdIn),
    .memRdEn     (memRdEn),
    .memAddr     (memAddr),
    .memRdData   (memRdData),
    .rfWrEn      (rfWrEn),
    .rfWrReg     (rfWrReg),
    .rfWrElem    (rfWrElem),
    .rfWrData    (rfWrData)
  );

  // R6/R9: reads only while a request is active, and the done cycle issues none
  a_r11_no_read_at_done: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !memRdEn);

endmodule

// File: tb/seg_load_unit_tb_top.sv
`timescale 1ns/1ps
module seg_load_unit_tb_top;

  localparam int XL  = 32;
  localparam int MVL = 8;
  localparam int NV  = 10;

  typedef struct packed {
    logic        unit;
    logic        idx;
    logic [31:0] base;
    logic [31:0] esz;
    logic [31:0] stride;
    logic [2:0]  seg;
    logic [3:0]  vl;
    logic        pen;
    logic        pinv;
    logic [7:0]  mask;
    logic [4:0]  rd;
  } vec_t;

  // unit, idx, base, esz, stride, seg, vl, pen, pinv, mask, rd
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 32'h0000_1000, 32'd4, 32'h99,        3'd0, 4'd8, 1'b0, 1'b0, 8'h00, 5'd2},  // R1 R4
    '{1'b0, 1'b0, 32'h0000_2000, 32'd4, 32'h20,        3'd0, 4'd5, 1'b0, 1'b0, 8'h00, 5'd10}, // R2 R4
    '{1'b1, 1'b0, 32'h0000_3000, 32'd2, 32'h0,         3'd2, 4'd4, 1'b0, 1'b0, 8'h00, 5'd4},  // R5
    '{1'b1, 1'b1, 32'h0000_4000, 32'd4, 32'h0,         3'd1, 4'd6, 1'b0, 1'b0, 8'h00, 5'd8},  // R3
    '{1'b0, 1'b0, 32'h0000_5000, 32'd4, 32'd16,        3'd0, 4'd8, 1'b1, 1'b0, 8'hB2, 5'd0},  // R6
    '{1'b0, 1'b0, 32'h0000_5000, 32'd4, 32'd16,        3'd1, 4'd8, 1'b1, 1'b1, 8'hB2, 5'd20}, // R6 inverted
    '{1'b0, 1'b0, 32'hFFFF_FFF0, 32'd4, 32'd8,         3'd1, 4'd4, 1'b0, 1'b0, 8'h00, 5'd31}, // R8, register wrap
    '{1'b1, 1'b0, 32'h0000_6000, 32'd4, 32'h0,         3'd3, 4'd0, 1'b0, 1'b0, 8'h00, 5'd1},  // R11 VL=0
    '{1'b0, 1'b1, 32'h0000_0200, 32'd4, 32'h0C,        3'd2, 4'd8, 1'b1, 1'b0, 8'h5D, 5'd12}, // R3 R6 R8
    '{1'b0, 1'b0, 32'h0000_7000, 32'd8, 32'hFFFF_FFF8, 3'd7, 4'd8, 1'b0, 1'b0, 8'h00, 5'd16}  // R5 max segment
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startIn = 1'b0;
  logic [XL-1:0]     baseIn = '0;
  logic [XL-1:0]     elemSizeIn = '0;
  logic [XL-1:0]     strideIn = '0;
  logic              unitStrideIn = 1'b0;
  logic              indexedIn = 1'b0;
  logic [MVL*XL-1:0] idxVecIn = '0;
  logic [2:0]        segLenIn = '0;
  logic [3:0]        vlIn = '0;
  logic              predEnIn = 1'b0;
  logic              predInvIn = 1'b0;
  logic [MVL-1:0]    predMaskIn = '0;
  logic [4:0]        rdIn = '0;
  logic              memRdEn;
  logic [XL-1:0]     memAddr;
  logic [XL-1:0]     memRdData = '0;
  logic              rfWrEn;
  logic [4:0]        rfWrReg;
  logic [2:0]        rfWrElem;
  logic [XL-1:0]     rfWrData;
  logic              busyOut;
  logic              doneOut;

  always #2 clk = ~clk;

  seg_load_unit dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .baseIn(baseIn),
    .elemSizeIn(elemSizeIn), .strideIn(strideIn), .unitStrideIn(unitStrideIn),
    .indexedIn(indexedIn), .idxVecIn(idxVecIn), .segLenIn(segLenIn),
    .vlIn(vlIn), .predEnIn(predEnIn), .predInvIn(predInvIn),
    .predMaskIn(predMaskIn), .rdIn(rdIn), .memRdEn(memRdEn),
    .memAddr(memAddr), .memRdData(memRdData), .rfWrEn(rfWrEn),
    .rfWrReg(rfWrReg), .rfWrElem(rfWrElem), .rfWrData(rfWrData),
    .busyOut(busyOut), .doneOut(doneOut)
  );

  function automatic logic [31:0] memFn(logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A5A_3C3C;
  endfunction

  function automatic logic [31:0] idxOf(int t, int i);
    logic [31:0] r;
    r = 32'(i) * 32'(40 + t * 8);
    if (t == 8) r = r + 32'hFFFF_FF00;
    return r;
  endfunction

  // synchronous memory model: one cycle of latency
  always @(posedge clk) memRdData <= memFn(memAddr);

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // monitor, sampled on the falling edge
  logic [31:0] issAddr [64];
  logic [4:0]  gotReg  [64];
  logic [2:0]  gotElem [64];
  logic [31:0] gotData [64];
  int nIss = 0, nWr = 0, busyCnt = 0, latErr = 0;
  logic prevRd = 1'b0;

  always @(negedge clk) begin
    if (busyOut) busyCnt++;
    if (memRdEn) begin
      if (nIss < 64) issAddr[nIss] = memAddr;
      nIss++;
    end
    if (rfWrEn) begin
      if (nWr < 64) begin
        gotReg[nWr]  = rfWrReg;
        gotElem[nWr] = rfWrElem;
        gotData[nWr] = rfWrData;
      end
      nWr++;
    end
    if (rfWrEn !== prevRd) latErr++;
    prevRd = memRdEn;
  end

  task automatic runVec(input int t);
    vec_t        v;
    logic [31:0] step, off, ea;
    logic [31:0] expAddr [64];
    logic [4:0]  expReg  [64];
    logic [2:0]  expElem [64];
    int          nExp, busyExp, w;
    bit          act;
    v = VECS[t];
    step = v.unit ? v.esz : v.stride;
    nExp = 0;
    busyExp = 2;
    for (int i = 0; i < int'(v.vl); i++) begin
      act = !v.pen || (v.mask[i] ^ v.pinv);
      busyExp += act ? int'(v.seg) + 1 : 1;
      if (act) begin
        for (int j = 0; j <= int'(v.seg); j++) begin
          off = v.idx ? idxOf(t, i) : 32'(i) * (32'(v.seg) + 32'd1) * step;
          ea  = v.base + off + 32'(j) * step;
          expAddr[nExp] = ea;
          expReg[nExp]  = 5'(v.rd + 5'(j));
          expElem[nExp] = 3'(i);
          nExp++;
        end
      end
    end

    @(negedge clk);
    baseIn = v.base; elemSizeIn = v.esz; strideIn = v.stride;
    unitStrideIn = v.unit; indexedIn = v.idx; segLenIn = v.seg;
    vlIn = v.vl; predEnIn = v.pen; predInvIn = v.pinv;
    predMaskIn = v.mask; rdIn = v.rd;
    for (int i = 0; i < MVL; i++) idxVecIn[i*XL +: XL] = idxOf(t, i);
    nIss = 0; nWr = 0; busyCnt = 0; latErr = 0;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    w = 0;
    while (!doneOut && w < 300) begin
      @(negedge clk);
      w++;
    end
    chk(w < 300, $sformatf("R11 vec %0d done never seen act=%0d exp=1", t, doneOut));
    @(negedge clk);
    chk(!doneOut && !busyOut,
        $sformatf("R11 vec %0d done/busy after end act=%b%b exp=00", t, doneOut, busyOut));
    chk(busyCnt == busyExp,
        $sformatf("R11 vec %0d busy cycles act=%0d exp=%0d", t, busyCnt, busyExp));
    chk(nIss == nExp && nWr == nExp,
        $sformatf("R6/R9 vec %0d reads/writes act=%0d/%0d exp=%0d", t, nIss, nWr, nExp));
    chk(latErr == 0,
        $sformatf("R7 vec %0d read-to-write latency mismatches act=%0d exp=0", t, latErr));
    for (int k = 0; k < nExp && k < nIss && k < nWr; k++) begin
      chk(issAddr[k] == expAddr[k],
          $sformatf("R1/R2/R3/R4/R5/R8/R9 vec %0d beat %0d addr act=%h exp=%h",
                    t, k, issAddr[k], expAddr[k]));
      chk(gotReg[k] == expReg[k] && gotElem[k] == expElem[k] &&
          gotData[k] == memFn(expAddr[k]),
          $sformatf("R5/R7/R9 vec %0d beat %0d reg/elem/data act=%0d/%0d/%h exp=%0d/%0d/%h",
                    t, k, gotReg[k], gotElem[k], gotData[k],
                    expReg[k], expElem[k], memFn(expAddr[k])));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busyOut && !doneOut && !memRdEn && !rfWrEn,
        $sformatf("R10 in reset busy/done/rd/wr act=%b%b%b%b exp=0000",
                  busyOut, doneOut, memRdEn, rfWrEn));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busyOut && !doneOut && !memRdEn && !rfWrEn,
        $sformatf("R10 after reset busy/done/rd/wr act=%b%b%b%b exp=0000",
                  busyOut, doneOut, memRdEn, rfWrEn));
    for (int t = 0; t < NV; t++) runVec(t);
    // R10: reset in mid-request returns to idle
    @(negedge clk);
    vlIn = 4'd8; segLenIn = 3'd3; predEnIn = 1'b0; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(!busyOut && !memRdEn && !rfWrEn && !doneOut,
        $sformatf("R10 mid-request reset busy/rd/wr/done act=%b%b%b%b exp=0000",
                  busyOut, memRdEn, rfWrEn, doneOut));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule